// File: doc/BRIEF.md
# Block-Erase Flash Command Controller with Erase Pause

This controller sequences block erase and word program operations for a boot-block flash array. A host writes one-byte commands on `cmd_code` with a single-cycle `cmd_we` strobe, and `blk_addr` selects the target block. The controller reports progress and errors through an 8-bit status byte. It also drives the read-path selection: array data or status byte, and whether an array read of the addressed block is permitted right now. The storage cells, charge pumps and real erase timing are not part of this block. A segment counter stands in for the erase time.

An erase is split into `NSEG` segments of `SEG_CYC` cycles. A pause request only takes effect at a segment boundary. While paused, the host may read other blocks, read status, or resume. Any other command is flagged as a sequence error. Program and erase requests are refused with status errors when the programming voltage is not good, or when they target the boot block (the highest block) while it is locked. Every finished or refused operation must be acknowledged: first a status read, then a clear.

This block has no streaming data path. All pins are plain control and status levels, and no back-pressure applies.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the status byte is 8'h80, the read path selects the array (`rd_status`=0), `rd_array_ok`=1 and `standby`=0.
- R2: Command codes: 8'hFF read array, 8'h70 read status, 8'h50 clear status, 8'h20 block erase, 8'h40 program, 8'hB0 pause erase, 8'hD0 resume erase. A strobe with `chip_en` low is ignored.
- R3: Status bit 7 (ready) reads 0 for exactly NSEG*SEG_CYC cycles after an erase is accepted, and for exactly SEG_CYC cycles after a program is accepted.
- R4: A pause request takes effect only at the next segment boundary, and status bit 6 (paused) is then 1. A request made during the last segment lets the erase complete, and the request is then discarded.
- R5: While paused, only read array, read status and resume are valid. Any other command sets status bit 1 (sequence error) and the controller stays paused.
- R6: While paused, `rd_array_ok` is 1 only when array mode is selected and `blk_addr` differs from the block being erased.
- R7: Resume continues the erase from the segment where it stopped. The busy time after resume is (NSEG-1)*SEG_CYC when the pause took effect at the first boundary.
- R8: While paused with `chip_en` low, `standby` is 1 and a resume cannot be accepted. When `chip_en` returns high, `standby` falls.
- R9: A completed or refused operation leaves an acknowledgement pending. While it is pending, erase and program commands are refused and set bit 1. A clear is ignored until a read-status command has been seen. Clear zeroes bits 5..1.
- R10: With `vpp_ok` low, an erase or program is refused: ready stays 1, and the controller sets bit 3 plus bit 5 (erase) or bit 4 (program).
- R11: Block NBLK-1 is locked when the effective write-protect input is low and `rst_hv` is low. An erase or program to it is then refused with bit 2 plus bit 5 or bit 4. Other blocks proceed normally.
- R12: The boot block is unlocked by `wp_in` high or `rst_hv` high. With parameter HAS_WP=0, `wp_in` is treated as low.
- R13: Read array selects the array path. Read status, erase, program and resume select the status path (`rd_status`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip enable, active high |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command byte |
| blk_addr | input | BW | Block address for commands and reads |
| vpp_ok | input | 1 | Programming voltage above lockout |
| wp_in | input | 1 | Write-protect level, high unlocks boot block |
| rst_hv | input | 1 | Reset pin at high voltage, unlocks boot block |
| status | output | 8 | {ready, paused, erase err, program err, voltage err, lock err, sequence err, 0} |
| rd_status | output | 1 | Read path returns status byte |
| rd_array_ok | output | 1 | Array read of `blk_addr` permitted |
| standby | output | 1 | Low-power standby while paused |

## Verification
A segment counter that has drifted shows up as a ready-low window of the wrong length. It also shows as a paused flag that rises a cycle early or late, and the bench measures this against the boundary on the first sample after each edge. A lost or stale pause request appears in the run after the resume, or in the next erase. A stray pending-acknowledge state first becomes visible when the next erase is refused with bit 1 set. Wrong lock or voltage decisions appear in the status byte on the cycle after the command is written.

// File: rtl/fec_pkg.sv
package fec_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_PROG, ST_SUSP} fec_state_e;

  localparam logic [7:0] OP_READ   = 8'hFF;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_CLEAR  = 8'h50;
  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_PROG   = 8'h40;
  localparam logic [7:0] OP_SUSP   = 8'hB0;
  localparam logic [7:0] OP_RESUME = 8'hD0;

  typedef struct packed {
    logic rd;
    logic st;
    logic clr;
    logic ers;
    logic prg;
    logic sus;
    logic res;
    logic bad;
  } fec_cmd_t;
endpackage

// File: rtl/fec_cmd_dec.sv
module fec_cmd_dec
  import fec_pkg::*;
(
  input  logic       strobe,
  input  logic [7:0] code,
  output fec_cmd_t   cmd
);
  always_comb begin
    cmd = '0;
    if (strobe) begin
      case (code)
        OP_READ:   cmd.rd  = 1'b1;
        OP_STATUS: cmd.st  = 1'b1;
        OP_CLEAR:  cmd.clr = 1'b1;
        OP_ERASE:  cmd.ers = 1'b1;
        OP_PROG:   cmd.prg = 1'b1;
        OP_SUSP:   cmd.sus = 1'b1;
        OP_RESUME: cmd.res = 1'b1;
        default:   cmd.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fec_lock.sv
module fec_lock #(
  parameter int NBLK   = 8,
  parameter int HAS_WP = 1,
  localparam int BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic [BW-1:0] blk,
  input  logic          vpp_ok,
  input  logic          wp_in,
  input  logic          rst_hv,
  output logic          vpp_fail,
  output logic          lock_fail
);
  localparam logic [BW-1:0] BOOT_BLK = BW'(NBLK - 1);
  logic wp_eff;

  generate
    if (HAS_WP != 0) begin : g_wp_pin
      assign wp_eff = wp_in;
    end else begin : g_wp_tied
      // no pin on this variant: behaves as if strapped low
      assign wp_eff = wp_in & 1'b0;
    end
  endgenerate

  assign vpp_fail  = ~vpp_ok;
  assign lock_fail = (blk == BOOT_BLK) & ~(wp_eff | rst_hv);
endmodule

// File: rtl/fec_seg_timer.sv
module fec_seg_timer #(
  parameter int NSEG    = 4,
  parameter int SEG_CYC = 16,
  localparam int CW = (SEG_CYC > 1) ? $clog2(SEG_CYC) : 1,
  localparam int SW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic seg_end,
  output logic last_seg
);
  logic [CW-1:0] cnt;
  logic [SW-1:0] seg;

  assign seg_end  = run && (cnt == CW'(SEG_CYC - 1));
  assign last_seg = (seg == SW'(NSEG - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      seg <= '0;
    end else if (start) begin
      cnt <= '0;
      seg <= '0;
    end else if (seg_end) begin
      cnt <= '0;
      if (!last_seg) seg <= seg + 1'b1;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fec_pkg::*;
#(
  parameter int NBLK    = 8,
  parameter int NSEG    = 4,
  parameter int SEG_CYC = 16,
  parameter int HAS_WP  = 1,
  localparam int BW     = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_en,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_code,
  input  logic [BW-1:0] blk_addr,
  input  logic          vpp_ok,
  input  logic          wp_in,
  input  logic          rst_hv,
  output logic [7:0]    status,
  output logic          rd_status,
  output logic          rd_array_ok,
  output logic          standby
);
  fec_state_e    state;
  fec_cmd_t      cmd;
  logic          vpp_fail, lock_fail;
  logic          seg_end, last_seg;
  logic          launch, run;
  logic          in_idle, in_susp;
  logic [BW-1:0] erase_blk;
  logic          susp_pend, done_pend, rd_seen;
  logic          e_err, p_err, v_err, l_err, q_err;

  fec_cmd_dec u_dec (
    .strobe (cmd_we & chip_en),
    .code   (cmd_code),
    .cmd    (cmd)
  );

  fec_lock #(.NBLK(NBLK), .HAS_WP(HAS_WP)) u_lock (
    .blk       (blk_addr),
    .vpp_ok    (vpp_ok),
    .wp_in     (wp_in),
    .rst_hv    (rst_hv),
    .vpp_fail  (vpp_fail),
    .lock_fail (lock_fail)
  );

  fec_seg_timer #(.NSEG(NSEG), .SEG_CYC(SEG_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .run      (run),
    .seg_end  (seg_end),
    .last_seg (last_seg)
  );

  assign in_idle = (state == ST_IDLE);
  assign in_susp = (state == ST_SUSP);
  assign run     = (state == ST_ERASE) || (state == ST_PROG);
  assign launch  = in_idle && (cmd.ers || cmd.prg) && !done_pend
                   && !vpp_fail && !lock_fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      erase_blk <= '0;
      susp_pend <= 1'b0;
      done_pend <= 1'b0;
      rd_seen   <= 1'b0;
      rd_status <= 1'b0;
      e_err     <= 1'b0;
      p_err     <= 1'b0;
      v_err     <= 1'b0;
      l_err     <= 1'b0;
      q_err     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd.rd) rd_status <= 1'b0;
          if (cmd.st) begin
            rd_status <= 1'b1;
            if (done_pend) rd_seen <= 1'b1;
          end
          if (cmd.clr && (!done_pend || rd_seen)) begin
            e_err     <= 1'b0;
            p_err     <= 1'b0;
            v_err     <= 1'b0;
            l_err     <= 1'b0;
            q_err     <= 1'b0;
            done_pend <= 1'b0;
            rd_seen   <= 1'b0;
          end
          if (cmd.ers || cmd.prg) begin
            rd_status <= 1'b1;
            if (done_pend) begin
              q_err <= 1'b1;
            end else if (vpp_fail || lock_fail) begin
              v_err     <= vpp_fail;
              l_err     <= ~vpp_fail;
              e_err     <= cmd.ers;
              p_err     <= cmd.prg;
              done_pend <= 1'b1;
              rd_seen   <= 1'b0;
            end else begin
              state     <= cmd.ers ? ST_ERASE : ST_PROG;
              erase_blk <= blk_addr;
              susp_pend <= 1'b0;
            end
          end
        end
        ST_ERASE: begin
          if (cmd.st)  rd_status <= 1'b1;
          if (cmd.sus) susp_pend <= 1'b1;
          if (seg_end) begin
            if (last_seg) begin
              state     <= ST_IDLE;
              done_pend <= 1'b1;
              rd_seen   <= 1'b0;
              susp_pend <= 1'b0;
            end else if (susp_pend || cmd.sus) begin
              state     <= ST_SUSP;
              susp_pend <= 1'b0;
            end
          end
        end
        ST_PROG: begin
          if (cmd.st) rd_status <= 1'b1;
          if (seg_end) begin
            state     <= ST_IDLE;
            done_pend <= 1'b1;
            rd_seen   <= 1'b0;
          end
        end
        ST_SUSP: begin
          if (cmd.rd) rd_status <= 1'b0;
          if (cmd.st) rd_status <= 1'b1;
          if (cmd.res) begin
            state     <= ST_ERASE;
            rd_status <= 1'b1;
          end
          if (cmd.clr || cmd.ers || cmd.prg || cmd.sus || cmd.bad)
            q_err <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign status      = {in_idle | in_susp, in_susp, e_err, p_err,
                        v_err, l_err, q_err, 1'b0};
  assign rd_array_ok = !rd_status &&
                       (in_idle || (in_susp && (blk_addr != erase_blk)));
  assign standby     = in_susp && !chip_en;
endmodule

// File: rtl/fec_checks.sv
module fec_checks
  import fec_pkg::*;
#(
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chip_en,
  input logic          cmd_we,
  input logic [7:0]    cmd_code,
  input logic          vpp_ok,
  input logic [BW-1:0] blk_addr,
  input logic [BW-1:0] erase_blk,
  input logic [7:0]    status,
  input logic          rd_array_ok,
  input logic          standby,
  input logic          seg_end,
  input logic          in_idle,
  input logic          in_susp,
  input logic          done_pend
);
  p_ready_in_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> status[7]);

  p_pause_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(seg_end));

  p_bad_cmd_in_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_susp && cmd_we && chip_en && cmd_code == OP_PROG)
      |=> (status[1] && status[6]));

  p_other_block_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_susp && rd_array_ok) |-> (blk_addr != erase_blk));

  p_standby_only_paused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> status[6]);

  p_no_resume_without_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && !chip_en) |=> status[6]);

  p_low_vpp_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !done_pend && cmd_we && chip_en && cmd_code == OP_ERASE && !vpp_ok)
      |=> (status[3] && status[5] && status[7]));
endmodule

bind flash_erase_ctrl fec_checks #(.BW(BW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chip_en     (chip_en),
  .cmd_we      (cmd_we),
  .cmd_code    (cmd_code),
  .vpp_ok      (vpp_ok),
  .blk_addr    (blk_addr),
  .erase_blk   (erase_blk),
  .status      (status),
  .rd_array_ok (rd_array_ok),
  .standby     (standby),
  .seg_end     (seg_end),
  .in_idle     (in_idle),
  .in_susp     (in_susp),
  .done_pend   (done_pend)
);

// File: tb/sim_flash_erase_ctrl.sv
`timescale 1ns/1ps
module sim_flash_erase_ctrl;
  localparam int NBLK = 8;
  localparam int NSEG = 4;
  localparam int SEG  = 16;

  logic clk = 1'b0;
  logic rst_n, chip_en, cmd_we, vpp_ok, wp_in, rst_hv;
  logic [7:0] cmd_code;
  logic [2:0] blk_addr;
  logic [7:0] st0, st1;
  logic rs0, rs1, ok0, ok1, sb0, sb1;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  flash_erase_ctrl #(.NBLK(NBLK), .NSEG(NSEG), .SEG_CYC(SEG), .HAS_WP(1)) u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cmd_we(cmd_we),
    .cmd_code(cmd_code), .blk_addr(blk_addr), .vpp_ok(vpp_ok), .wp_in(wp_in),
    .rst_hv(rst_hv), .status(st0), .rd_status(rs0), .rd_array_ok(ok0),
    .standby(sb0));

  flash_erase_ctrl #(.NBLK(NBLK), .NSEG(NSEG), .SEG_CYC(SEG), .HAS_WP(0)) u1 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cmd_we(cmd_we),
    .cmd_code(cmd_code), .blk_addr(blk_addr), .vpp_ok(vpp_ok), .wp_in(wp_in),
    .rst_hv(rst_hv), .status(st1), .rd_status(rs1), .rd_array_ok(ok1),
    .standby(sb1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; command sampled at the next posedge
  task automatic issue(input logic [7:0] c, input logic [2:0] b);
    cmd_code = c;
    blk_addr = b;
    cmd_we   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_we   = 1'b0;
  endtask

  task automatic ack();
    issue(8'h70, 3'd0);
    issue(8'h50, 3'd0);
  endtask

  task automatic busy_count(output int n);
    n = 0;
    while (!st0[7] && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] exp_stat(input logic ers, input logic [2:0] b,
                                          input logic vp, input logic wp,
                                          input logic hv);
    logic [7:0] opb;
    opb = ers ? 8'h20 : 8'h10;
    if (!vp) return 8'h88 | opb;
    if (b == 3'(NBLK - 1) && !(wp || hv)) return 8'h84 | opb;
    return 8'h80;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n, c, guard;
    int unsigned seed;
    logic saw;
    seed = 32'h00C0FFEE;
    void'($urandom(seed));
    rst_n = 1'b0; chip_en = 1'b1; cmd_we = 1'b0; cmd_code = 8'h00;
    blk_addr = 3'd0; vpp_ok = 1'b1; wp_in = 1'b0; rst_hv = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", st0, 8'h80);
    chk("R1 rd_status", rs0, 0);
    chk("R1 rd_array_ok", ok0, 1);
    chk("R1 standby", sb0, 0);

    // R2 strobe with chip enable low ignored
    chip_en = 1'b0;
    issue(8'h20, 3'd2);
    chk("R2 ignored without chip_en", st0, 8'h80);
    chip_en = 1'b1;

    // R3 erase length, R13 status path
    issue(8'h20, 3'd2);
    chk("R13 erase selects status", rs0, 1);
    busy_count(n);
    chk("R3 erase busy cycles", n, NSEG * SEG);
    chk("R3 erase done status", st0, 8'h80);

    // R9 acknowledge handshake
    issue(8'h40, 3'd3);
    chk("R9 program refused while pending", st0, 8'h82);
    issue(8'h50, 3'd0);
    chk("R9 clear before status read ignored", st0, 8'h82);
    ack();
    chk("R9 clear after status read", st0, 8'h80);
    issue(8'hFF, 3'd3);
    chk("R13 read array path", rs0, 0);
    chk("R13 array read permitted", ok0, 1);

    // R3 program length
    issue(8'h40, 3'd3);
    busy_count(n);
    chk("R3 program busy cycles", n, SEG);
    ack();

    // R4 pause at boundary, R5 R6 R7 R8
    issue(8'h20, 3'd5);
    issue(8'hB0, 3'd5);
    c = 0;
    while (!st0[6] && c < 1000) begin
      @(negedge clk);
      c++;
    end
    chk("R4 pause latency to boundary", c, SEG - 1);
    chk("R4 paused status", st0, 8'hC0);
    issue(8'h40, 3'd1);
    chk("R5 program while paused flagged", st0, 8'hC2);
    issue(8'h20, 3'd1);
    chk("R5 erase while paused stays paused", st0[6], 1);
    issue(8'hFF, 3'd0);
    chk("R13 read array while paused", rs0, 0);
    blk_addr = 3'd5; #1;
    chk("R6 paused block not readable", ok0, 0);
    blk_addr = 3'd4; #1;
    chk("R6 other block readable", ok0, 1);
    @(negedge clk);
    chip_en = 1'b0; #1;
    chk("R8 standby raised", sb0, 1);
    @(negedge clk);
    issue(8'hD0, 3'd5);
    chk("R8 resume refused without chip_en", st0, 8'hC2);
    chip_en = 1'b1; #1;
    chk("R8 standby dropped", sb0, 0);
    @(negedge clk);
    issue(8'hD0, 3'd5);
    busy_count(n);
    chk("R7 remaining busy after resume", n, (NSEG - 1) * SEG);
    chk("R7 finished with sequence flag", st0, 8'h82);
    ack();
    chk("R9 cleared", st0, 8'h80);

    // R4 request in last segment: erase completes
    issue(8'h20, 3'd1);
    repeat ((NSEG - 1) * SEG + 1) @(negedge clk);
    issue(8'hB0, 3'd1);
    saw = 1'b0;
    guard = 0;
    while (!st0[7] && guard < 1000) begin
      if (st0[6]) saw = 1'b1;
      @(negedge clk);
      guard++;
    end
    chk("R4 last segment never paused", {saw, st0}, {1'b0, 8'h80});
    ack();
    issue(8'h20, 3'd1);
    busy_count(n);
    chk("R4 stale request discarded", n, NSEG * SEG);
    ack();

    // R10 R11 R12 random protection mix; u1 has no write-protect pin
    for (int i = 0; i < 40; i++) begin
      logic ers, vp, wp, hv;
      logic [2:0] b;
      ers = 1'($urandom % 2);
      vp  = ($urandom % 4) != 0;
      wp  = 1'($urandom % 2);
      hv  = ($urandom % 3) == 0;
      b   = (($urandom % 3) == 0) ? 3'(NBLK - 1) : 3'($urandom_range(NBLK - 1, 0));
      vpp_ok = vp; wp_in = wp; rst_hv = hv;
      issue(ers ? 8'h20 : 8'h40, b);
      guard = 0;
      while (!(st0[7] && st1[7]) && guard < 1000) begin
        @(negedge clk);
        guard++;
      end
      chk(!vp ? "R10 low voltage" : "R11 R12 lock pin", st0, exp_stat(ers, b, vp, wp, hv));
      chk("R12 tied-low variant", st1, exp_stat(ers, b, vp, 1'b0, hv));
      vpp_ok = 1'b1;
      ack();
    end
    chk("R9 final clear", {st0, st1}, {8'h80, 8'h80});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule